// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Port Pair

This block sits between a microcontroller core and two 8-bit pin groups. With the mode input high at start-up it runs an external bus. Every bus cycle is two clocks long. In the first clock the E clock is low, and the low pin group carries the bottom address byte while an address strobe tells outside logic to latch it. In the second clock E is high and the same pins carry data. During that data phase the pins drive the core's write data on a write, or are released and sampled on a read. The high pin group carries the top address byte on every cycle.

With the mode input low at start-up, the two groups are plain ports. The high group is eight outputs driven from an internal register. The low group is eight lines whose direction is set bit by bit, backed by a data latch. The core reaches these registers through the same access interface and cycle timing.

The mode is sampled once, on the first clock after reset is released. Until that clock every pin is released. The core presents an access and holds it until `acc_take` is seen high at a clock edge. Read results come back with a one-cycle valid pulse.

Top module: `mux_bus_if`

## Requirements
- R1: While reset is asserted, and up to the first rising clock edge after it is released, `hi_oe` and `lo_oe` are all zero, and `e_clk`, `as_strb` and `acc_rvalid` are low.
- R2: Once running, `e_clk` alternates on every clock: low in the address phase and high in the data phase. `acc_take` is high in every data phase and in the sampling cycle right after reset. An access held at the edge that ends such a cycle belongs to the next bus cycle.
- R3: In expanded mode (`mode_exp` = 1 when sampled), `hi_out` carries address bits 15..8 of the current bus cycle and `hi_oe` is all ones, in both phases.
- R4: In the expanded address phase, `lo_out` equals address bits 7..0, `lo_oe` is all ones and `as_strb` is high. `as_strb` is low in the data phase.
- R5: In the data phase of an expanded write, `lo_out` equals the write data and `lo_oe` is all ones.
- R6: In the data phase of an expanded read, `lo_oe` is all zero. The value on `lo_in` at the edge where E falls is returned on `acc_rdata`, with `acc_rvalid` high for exactly the following cycle.
- R7: In expanded mode, an access to `HI_REG_ADDR` is handled as an external bus cycle: a write drives its data onto the low pins, and a read returns the low pins and not the internal register.
- R8: In single-chip mode (`mode_exp` = 0 when sampled), `hi_oe` is all ones and `hi_out` shows the last value written to `HI_REG_ADDR` (0 after reset). A read of that address returns the same value. `as_strb` stays low.
- R9: In single-chip mode, writes to `LO_DIR_ADDR` set the direction (bit = 1 means output), and `lo_oe` equals that register. Writes to `LO_REG_ADDR` set the latch, which `lo_out` shows. A read of `LO_REG_ADDR` returns the latch on output bits and `lo_in` on input bits. A read of `LO_DIR_ADDR` returns the direction. Register writes take effect at the edge that ends the data phase.
- R10: Changes on `mode_exp` after the sampling clock have no effect until the next reset.
- R11: A bus cycle with `acc_req` low drives nothing in its data phase and produces no `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each bus cycle lasts two periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_exp | input | 1 | 1 = expanded bus, 0 = single-chip ports; sampled once after reset |
| acc_req | input | 1 | Core access request |
| acc_addr | input | 2*PW | Access address |
| acc_wdata | input | PW | Write data |
| acc_rnw | input | 1 | 1 = read, 0 = write |
| acc_take | output | 1 | High when the access inputs are captured at the next edge |
| acc_rdata | output | PW | Read result |
| acc_rvalid | output | 1 | One-cycle pulse marking `acc_rdata` valid |
| e_clk | output | 1 | Bus E clock; high during the data phase |
| as_strb | output | 1 | Address strobe; high during the expanded address phase |
| hi_out | output | PW | High pin group output values |
| hi_oe | output | PW | High pin group output enables |
| lo_out | output | PW | Low pin group output values |
| lo_oe | output | PW | Low pin group output enables |
| lo_in | input | PW | Low pin group sampled levels |

## Verification
The bench builds the block with its default parameters: 8-bit pin groups, a 16-bit address, and the high port, low port and low direction registers at 0x1004, 0x1003 and 0x1007. With these values a vector table of expanded reads and writes can hit the all-ones and all-zeros address and data bytes. The same table includes accesses to 0x1004, which must leave the chip, so the expanded-mode bypass of the high port register is reached. Directed tests then reset into single-chip mode and use a mixed direction mask of 0x0F. A single read of the low port therefore shows the latch on some bits and the pins on others.

// File: rtl/mux_bus_if.sv
module mux_bus_if #(
  parameter int PW = 8,
  parameter logic [2*PW-1:0] HI_REG_ADDR = 'h1004,
  parameter logic [2*PW-1:0] LO_REG_ADDR = 'h1003,
  parameter logic [2*PW-1:0] LO_DIR_ADDR = 'h1007
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_exp,
  input  logic            acc_req,
  input  logic [2*PW-1:0] acc_addr,
  input  logic [PW-1:0]   acc_wdata,
  input  logic            acc_rnw,
  output logic            acc_take,
  output logic [PW-1:0]   acc_rdata,
  output logic            acc_rvalid,
  output logic            e_clk,
  output logic            as_strb,
  output logic [PW-1:0]   hi_out,
  output logic [PW-1:0]   hi_oe,
  output logic [PW-1:0]   lo_out,
  output logic [PW-1:0]   lo_oe,
  input  logic [PW-1:0]   lo_in
);
  localparam int AW = 2 * PW;

  logic            run_q, mode_q, ph_q;
  logic [AW-1:0]   a_addr;
  logic [PW-1:0]   a_wdata;
  logic            a_rnw, a_req;
  logic [PW-1:0]   hi_q, lo_q, dir_q, rd_q, int_rd;
  logic            rv_q;

  assign acc_take = ~run_q | ph_q;

  always_comb begin
    int_rd = '0;
    if (a_addr == HI_REG_ADDR)      int_rd = hi_q;
    else if (a_addr == LO_REG_ADDR) int_rd = (lo_in & ~dir_q) | (lo_q & dir_q);
    else if (a_addr == LO_DIR_ADDR) int_rd = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      ph_q    <= 1'b0;
      a_addr  <= '0;
      a_wdata <= '0;
      a_rnw   <= 1'b1;
      a_req   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      dir_q   <= '0;
      rd_q    <= '0;
      rv_q    <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (!run_q) mode_q <= mode_exp;
      ph_q <= run_q & ~ph_q;
      rv_q <= 1'b0;
      if (acc_take) begin
        if (run_q && a_req) begin
          if (a_rnw) begin
            rv_q <= 1'b1;
            rd_q <= mode_q ? lo_in : int_rd;
          end else if (!mode_q) begin
            if (a_addr == HI_REG_ADDR) hi_q  <= a_wdata;
            if (a_addr == LO_REG_ADDR) lo_q  <= a_wdata;
            if (a_addr == LO_DIR_ADDR) dir_q <= a_wdata;
          end
        end
        a_addr  <= acc_addr;
        a_wdata <= acc_wdata;
        a_rnw   <= acc_rnw | ~acc_req;
        a_req   <= acc_req;
      end
    end
  end

  assign acc_rdata  = rd_q;
  assign acc_rvalid = rv_q;
  assign e_clk      = ph_q;
  assign as_strb    = run_q & mode_q & ~ph_q;
  assign hi_out     = mode_q ? a_addr[AW-1:PW] : hi_q;
  assign hi_oe      = {PW{run_q}};
  assign lo_out     = mode_q ? (ph_q ? a_wdata : a_addr[PW-1:0]) : lo_q;

  always_comb begin
    if (!run_q)                  lo_oe = '0;
    else if (!mode_q)            lo_oe = dir_q;
    else if (!ph_q || !a_rnw)    lo_oe = '1;
    else                         lo_oe = '0;
  end
endmodule

// File: rtl/mux_bus_if_chk.sv
module mux_bus_if_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic          mode_q,
  input logic          a_rnw,
  input logic          e_clk,
  input logic          as_strb,
  input logic          acc_take,
  input logic          acc_rvalid,
  input logic [PW-1:0] hi_out,
  input logic [PW-1:0] hi_oe,
  input logic [PW-1:0] lo_oe
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (hi_oe == '0 && lo_oe == '0 && !e_clk));

  p_e_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> (e_clk != $past(e_clk)));

  p_hi_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $past(run_q) && !$past(acc_take)) |-> $stable(hi_out));

  p_strb_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    as_strb |-> (!e_clk && lo_oe == '1));

  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && e_clk && a_rnw) |-> lo_oe == '0);

  p_rvalid_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $fell(e_clk));

  p_single_no_strb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !as_strb);

  p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(mode_q));
endmodule

bind mux_bus_if mux_bus_if_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .mode_q(mode_q), .a_rnw(a_rnw),
  .e_clk(e_clk), .as_strb(as_strb), .acc_take(acc_take), .acc_rvalid(acc_rvalid),
  .hi_out(hi_out), .hi_oe(hi_oe), .lo_oe(lo_oe)
);

// File: tb/mux_bus_if_tb.sv
`timescale 1ns/1ps
module mux_bus_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_exp = 1'b1;
  logic        acc_req = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        acc_rnw = 1'b1;
  logic        acc_take, acc_rvalid, e_clk, as_strb;
  logic [7:0]  acc_rdata, hi_out, hi_oe, lo_out, lo_oe;
  logic [7:0]  lo_in = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_if u_dut (
    .clk(clk), .rst_n(rst_n), .mode_exp(mode_exp), .acc_req(acc_req),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rnw(acc_rnw),
    .acc_take(acc_take), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .e_clk(e_clk), .as_strb(as_strb), .hi_out(hi_out), .hi_oe(hi_oe),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        rnw;
    logic [7:0]  pins;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h1234, 8'h5A, 1'b0, 8'h00},
    '{16'hFFFF, 8'h00, 1'b1, 8'hC3},
    '{16'h0000, 8'hFF, 1'b0, 8'h11},
    '{16'h1004, 8'h77, 1'b0, 8'h00},
    '{16'h1004, 8'h00, 1'b1, 8'h3E},
    '{16'h8001, 8'h00, 1'b1, 8'h00},
    '{16'h00FF, 8'h00, 1'b0, 8'hFF},
    '{16'hABCD, 8'h00, 1'b1, 8'hA5}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    mode_exp = m;
    acc_req = 1'b0;
    lo_in = '0;
    repeat (3) @(negedge clk);
    chk(hi_oe == 0 && lo_oe == 0 && !e_clk && !as_strb && !acc_rvalid, "R1 in reset",
        {hi_oe, lo_oe}, 16'h0000);
    rst_n = 1'b1;
    #0.5;
    chk(hi_oe == 0 && lo_oe == 0 && !e_clk, "R1 before sample", {hi_oe, lo_oe}, 16'h0000);
    chk(acc_take == 1'b1, "R2 take at sample", {15'd0, acc_take}, 16'h0001);
  endtask

  // Called at a negedge where acc_take is high; returns at a data-phase negedge.
  task automatic bus(input logic req, input logic [15:0] addr, input logic [7:0] wd,
                     input logic rnw, input logic [7:0] pins, input logic [7:0] exp_rd,
                     input logic exp_mode);
    acc_req = req; acc_addr = addr; acc_wdata = wd; acc_rnw = rnw;
    @(posedge clk); @(negedge clk);
    chk(e_clk == 1'b0, "R2 E low in address phase", {15'd0, e_clk}, 16'h0000);
    if (exp_mode) begin
      chk(hi_out == addr[15:8] && hi_oe == 8'hFF, "R3 high byte addr phase",
          {hi_out, hi_oe}, {addr[15:8], 8'hFF});
      chk(lo_out == addr[7:0] && lo_oe == 8'hFF && as_strb, "R4 low byte and strobe",
          {lo_out, lo_oe}, {addr[7:0], 8'hFF});
    end
    lo_in = pins;
    @(posedge clk); @(negedge clk);
    chk(e_clk == 1'b1 && acc_take, "R2 E high in data phase", {14'd0, e_clk, acc_take}, 16'h0003);
    if (exp_mode) begin
      chk(!as_strb && hi_out == addr[15:8], "R3 R4 data phase", {7'd0, as_strb, hi_out}, {8'd0, addr[15:8]});
      if (req && !rnw)
        chk(lo_out == wd && lo_oe == 8'hFF, "R5 write data driven", {lo_out, lo_oe}, {wd, 8'hFF});
      else if (req)
        chk(lo_oe == 8'h00, "R6 read releases pins", {8'd0, lo_oe}, 16'h0000);
      else
        chk(lo_oe == 8'h00, "R11 idle releases pins", {8'd0, lo_oe}, 16'h0000);
    end
    acc_req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(acc_rvalid == (req & rnw), "R6 R11 valid pulse", {15'd0, acc_rvalid}, {15'd0, req & rnw});
    if (req && rnw)
      chk(acc_rdata == exp_rd, "R6 R7 R8 R9 read data", {8'd0, acc_rdata}, {8'd0, exp_rd});
    @(posedge clk); @(negedge clk);
    chk(acc_rvalid == 1'b0, "R6 single-cycle valid", {15'd0, acc_rvalid}, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    foreach (VEC[i]) begin
      bus(1'b1, VEC[i].addr, VEC[i].wd, VEC[i].rnw, VEC[i].pins, VEC[i].pins, 1'b1);
    end
    // R7: write to the high port register address still goes out on the bus
    bus(1'b1, 16'h1004, 8'h99, 1'b0, 8'h00, 8'h00, 1'b1);
    bus(1'b1, 16'h1004, 8'h00, 1'b1, 8'h42, 8'h42, 1'b1);
    chk(hi_out == 8'h10, "R7 high port shows address not register", {8'd0, hi_out}, 16'h0010);
    // R11: idle bus cycle
    bus(1'b0, 16'h2345, 8'hEE, 1'b0, 8'h00, 8'h00, 1'b1);
    // R10: mode change after sampling ignored
    mode_exp = 1'b0;
    bus(1'b1, 16'h5A3C, 8'h81, 1'b0, 8'h00, 8'h00, 1'b1);
    acc_addr = 16'h6B4D;
    acc_req = 1'b1; acc_rnw = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(as_strb && hi_out == 8'h6B && lo_out == 8'h4D, "R10 still expanded",
        {hi_out, lo_out}, 16'h6B4D);
    acc_req = 1'b0;
    @(posedge clk); @(negedge clk);

    // Single-chip mode
    do_reset(1'b0);
    bus(1'b0, 16'h0000, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0);
    chk(hi_out == 8'h00 && hi_oe == 8'hFF && lo_oe == 8'h00 && !as_strb, "R8 R9 reset ports",
        {hi_out, lo_oe}, 16'h0000);
    bus(1'b1, 16'h1004, 8'hA5, 1'b0, 8'h00, 8'h00, 1'b0);
    chk(hi_out == 8'hA5 && hi_oe == 8'hFF, "R8 high port register drives", {hi_out, hi_oe}, 16'hA5FF);
    chk(!as_strb, "R8 no strobe", {15'd0, as_strb}, 16'h0000);
    bus(1'b1, 16'h1007, 8'h0F, 1'b0, 8'h00, 8'h00, 1'b0);
    chk(lo_oe == 8'h0F, "R9 direction to enables", {8'd0, lo_oe}, 16'h000F);
    bus(1'b1, 16'h1003, 8'h3C, 1'b0, 8'h00, 8'h00, 1'b0);
    chk(lo_out == 8'h3C && lo_oe == 8'h0F, "R9 latch drives pins", {lo_out, lo_oe}, 16'h3C0F);
    bus(1'b1, 16'h1003, 8'h00, 1'b1, 8'h96, 8'h9C, 1'b0);
    bus(1'b1, 16'h1007, 8'h00, 1'b1, 8'h00, 8'h0F, 1'b0);
    bus(1'b1, 16'h1004, 8'h00, 1'b1, 8'h00, 8'hA5, 1'b0);
    bus(1'b1, 16'h1234, 8'h00, 1'b1, 8'h55, 8'h00, 1'b0);
    chk(hi_out == 8'hA5 && lo_out == 8'h3C, "R9 R8 ports unchanged by unmapped read",
        {hi_out, lo_out}, 16'hA53C);
    report();
    $finish;
  end
endmodule